// File: doc/BRIEF.md
# Symmetric int8 Quantized Dot-Product Engine

This block forms an approximate dot product of two vectors whose elements arrive as signed Q8.8 words. It has no floating-point hardware. Each element is multiplied by a per-vector scale, rounded to the nearest integer and limited to the symmetric 8-bit range. The 8-bit codes of the two vectors are multiplied pairwise and summed in an integer accumulator. The integer sum is then divided by the product of the two scales, which gives a signed Q16.16 result.

The block has two scale modes. In dynamic mode it first finds the largest element magnitude of each vector, then derives that vector's scale so that the peak lands exactly on ±127. Because of this the block stores the whole vector before it starts quantizing. In static mode the two scales are taken from input ports. Any code that would fall outside the 8-bit range is clamped. Scales are unsigned Q16.16 reciprocals, so quantizing each element needs a multiply and no divide. The engine has one shared sequential divider. It is used only a few times per vector: up to twice to derive the scales, and once to rescale the sum.

Element pairs enter on a valid/ready stream and a flag marks the last pair. After the last pair the block computes the result, presents it with a one-cycle done pulse and holds it until the consumer acknowledges it.

Top module: `qdot_engine`

## Requirements
- R1: `in_ready` is high only while the block is collecting a vector. A pair is taken on every cycle where `in_valid` and `in_ready` are both high. The vector ends on the pair that carries `in_last`, or on the MAX_LEN-th pair, whichever comes first.
- R2: No quantized code is ever -128. Every code lies in [-127, 127], even for the input -32768 under a large scale.
- R3: An element x with scale s gives the code sign(x)·min(127, floor((|x|·s + 2^23) / 2^24)). Here x is the raw Q8.8 value and s is the raw unsigned Q16.16 scale, so rounding is half away from zero.
- R4: In dynamic mode a vector's scale is floor(127·2^24 / m), where m is the largest raw magnitude in that vector. Every element whose magnitude equals m therefore quantizes to +127 or -127.
- R5: In static mode the scales are the values on `scale_a` and `scale_b` at the first pair of the vector. Codes beyond the range are clamped to ±127.
- R6: The accumulator holds the exact integer sum of the products of the code pairs over the whole vector.
- R7: Let A be the accumulator and S be the product of the two raw scales. The result is sign(A)·floor((|A|·2^49 + S) / (2·S)) in Q16.16. It saturates to +2147483647 or -2147483647.
- R8: If a vector is all zeros in dynamic mode, its scale is 0. If either scale is 0, the result is exactly 0 and no fault occurs.
- R9: `res_done` is high for exactly one cycle. `res_q` stays stable and `in_ready` stays low from the cycle after the last pair until `res_ack` is seen. Pairs offered during that time are ignored.
- R10: The value of `mode_static` at the first pair selects the mode for the whole vector. Later changes to it, or to the scale ports, have no effect on that vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An element pair is offered |
| in_ready | output | 1 | The block accepts a pair this cycle |
| in_a | input | 16 | Element of vector A, signed Q8.8 |
| in_b | input | 16 | Element of vector B, signed Q8.8 |
| in_last | input | 1 | This pair is the last of the vector |
| mode_static | input | 1 | 1 selects the fixed scales, 0 selects the derived scales |
| scale_a | input | 32 | Fixed scale for A, unsigned Q16.16 |
| scale_b | input | 32 | Fixed scale for B, unsigned Q16.16 |
| res_q | output | 32 | Dot-product result, signed Q16.16 |
| res_done | output | 1 | One-cycle pulse when `res_q` becomes valid |
| res_ack | input | 1 | The consumer has taken the result |

## Verification
Some properties are checked on every cycle:
- No code ever equals -128.
- A peak element in dynamic mode always reaches full scale.
- A dynamic vector whose peak is zero gives only zero codes.
- The done pulse lasts one cycle.
- The result stays frozen and input stays stalled while it waits for acknowledgement.

Only the bench scenarios can show that the rounding, the clamp, the derived scale, the accumulated sum and the saturating rescale yield the right final number. The same holds for mode latching at the first pair and for the end of a vector at the length limit. The bench compares the final number against a reference model that it computes on its own.

// File: rtl/qdot_pkg.sv
package qdot_pkg;
  localparam int IN_W     = 16;               // signed input word
  localparam int IN_FRAC  = 8;
  localparam int SC_W     = 32;               // unsigned reciprocal scale
  localparam int SC_FRAC  = 16;
  localparam int OUT_W    = 32;               // signed result word
  localparam int OUT_FRAC = 16;
  localparam int Q_W      = 8;
  localparam int Q_MAX    = 127;
  localparam int QSH      = IN_FRAC + SC_FRAC;              // element * scale -> integer
  localparam int DQ_SHIFT = 2 * SC_FRAC + OUT_FRAC + 1;     // extra bit for rounding
  localparam int PROD_W   = IN_W + 1 + SC_W;

  typedef enum logic [3:0] {
    ST_LOAD, ST_KSA, ST_WSA, ST_KSB, ST_WSB, ST_MAC, ST_KDQ, ST_WDQ, ST_HOLD
  } qdot_state_t;

  function automatic logic [IN_W:0] mag_of(input logic signed [IN_W-1:0] x);
    logic [IN_W:0] xe;
    xe = {x[IN_W-1], x};
    return x[IN_W-1] ? (~xe + 1'b1) : xe;
  endfunction

  // R3: round half away from zero on the magnitude, R2/R5: clamp to 127
  function automatic logic signed [Q_W-1:0] quantize(input logic signed [IN_W-1:0] x,
                                                     input logic [SC_W-1:0] s);
    logic [PROD_W-1:0] p;
    logic [PROD_W-1:0] r;
    p = PROD_W'(mag_of(x)) * PROD_W'(s);
    r = (p + (PROD_W'(1) << (QSH - 1))) >> QSH;
    if (r > PROD_W'(Q_MAX)) r = PROD_W'(Q_MAX);
    return x[IN_W-1] ? -Q_W'(r) : Q_W'(r);
  endfunction
endpackage

// File: rtl/qdot_div.sv
module qdot_div #(
  parameter int NUM_W = 73,
  parameter int DEN_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W:0]   rem;
  logic [DEN_W-1:0] dvs;
  logic [CNT_W-1:0] cnt;
  logic             run;
  logic [DEN_W:0]   rem_sh;
  logic             ge;

  assign rem_sh = {rem[DEN_W-1:0], quo[NUM_W-1]};
  assign ge     = rem_sh >= {1'b0, dvs};

  // restoring division, one quotient bit per cycle; zero divisor gives zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem <= '0; dvs <= '0; cnt <= '0; run <= 1'b0; done <= 1'b0; quo <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem <= '0;
        dvs <= den;
        cnt <= CNT_W'(NUM_W);
        if (den == '0) begin
          quo  <= '0;
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          quo <= num;
          run <= 1'b1;
        end
      end else if (run) begin
        rem <= ge ? (rem_sh - {1'b0, dvs}) : rem_sh;
        quo <= {quo[NUM_W-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CNT_W'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/qdot_mac.sv
module qdot_mac import qdot_pkg::*; #(
  parameter int ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic signed [IN_W-1:0]  a,
  input  logic signed [IN_W-1:0]  b,
  input  logic [SC_W-1:0]         sa,
  input  logic [SC_W-1:0]         sb,
  output logic signed [Q_W-1:0]   qa,
  output logic signed [Q_W-1:0]   qb,
  output logic signed [ACC_W-1:0] acc
);
  logic signed [2*Q_W-1:0] prod;

  assign qa   = quantize(a, sa);
  assign qb   = quantize(b, sb);
  assign prod = qa * qb;

  // R6: exact integer sum of code products
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc <= '0;
    else if (clr) acc <= '0;
    else if (en)  acc <= acc + ACC_W'(prod);
  end
endmodule

// File: rtl/qdot_engine.sv
module qdot_engine import qdot_pkg::*; #(
  parameter int MAX_LEN = 64,
  parameter int ACC_W   = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_a,
  input  logic signed [IN_W-1:0]  in_b,
  input  logic                    in_last,
  input  logic                    mode_static,
  input  logic [SC_W-1:0]         scale_a,
  input  logic [SC_W-1:0]         scale_b,
  output logic signed [OUT_W-1:0] res_q,
  output logic                    res_done,
  input  logic                    res_ack
);
  localparam int IDX_W = $clog2(MAX_LEN);
  localparam int LEN_W = $clog2(MAX_LEN + 1);
  localparam int DEN_W = 2 * SC_W;
  localparam int NUM_W = ACC_W + DQ_SHIFT;
  localparam logic [OUT_W-1:0] OUT_MAX = {1'b0, {(OUT_W-1){1'b1}}};

  qdot_state_t state;
  logic [IDX_W-1:0] idx, k;
  logic [LEN_W-1:0] len_r;
  logic [IN_W:0]    ma_r, mb_r;
  logic [SC_W-1:0]  sa_r, sb_r;
  logic             mode_r;

  logic signed [IN_W-1:0] buf_a [MAX_LEN];
  logic signed [IN_W-1:0] buf_b [MAX_LEN];

  // named internal events
  logic beat_w, first_w, last_beat_w, mode_eff_w, mac_en_w, last_k_w, div_start_w, div_done_w;
  logic signed [IN_W-1:0]  cur_a_w, cur_b_w;
  logic signed [Q_W-1:0]   qa_w, qb_w;
  logic signed [ACC_W-1:0] acc_w;
  logic [ACC_W-1:0]        acc_mag_w;
  logic [IN_W:0]           mag_in_a_w, mag_in_b_w;
  logic [NUM_W-1:0]        div_num, div_quo;
  logic [DEN_W-1:0]        div_den;

  assign in_ready    = (state == ST_LOAD);                        // R1
  assign beat_w      = in_valid && in_ready;
  assign first_w     = (idx == '0);
  assign last_beat_w = in_last || (idx == IDX_W'(MAX_LEN - 1));
  assign mode_eff_w  = first_w ? mode_static : mode_r;            // R10
  assign mac_en_w    = (state == ST_MAC);
  assign last_k_w    = (LEN_W'(k) == len_r - LEN_W'(1));
  assign div_start_w = (state == ST_KSA) || (state == ST_KSB) || (state == ST_KDQ);
  assign cur_a_w     = buf_a[k];
  assign cur_b_w     = buf_b[k];
  assign mag_in_a_w  = mag_of(in_a);
  assign mag_in_b_w  = mag_of(in_b);
  assign acc_mag_w   = acc_w[ACC_W-1] ? -acc_w : acc_w;

  // R7: half-away rounding of the doubled quotient, then saturation
  function automatic logic signed [OUT_W-1:0] dq_finish(input logic [NUM_W-1:0] q2,
                                                        input logic neg);
    logic [NUM_W:0]   r;
    logic [OUT_W-1:0] m;
    r = ({1'b0, q2} + (NUM_W+1)'(1)) >> 1;
    m = (r > (NUM_W+1)'(OUT_MAX)) ? OUT_MAX : r[OUT_W-1:0];
    return neg ? -m : m;
  endfunction

  // R4 numerator for the derived scale, R7 numerator for the rescale
  always_comb begin
    div_num = NUM_W'(Q_MAX) << QSH;
    div_den = DEN_W'(ma_r);
    if (state == ST_KSB) div_den = DEN_W'(mb_r);
    if (state == ST_KDQ) begin
      div_num = NUM_W'(acc_mag_w) << DQ_SHIFT;
      div_den = DEN_W'(sa_r) * DEN_W'(sb_r);
    end
  end

  always_ff @(posedge clk) begin
    if (beat_w) begin
      buf_a[idx] <= in_a;
      buf_b[idx] <= in_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOAD; idx <= '0; k <= '0; len_r <= '0;
      ma_r <= '0; mb_r <= '0; sa_r <= '0; sb_r <= '0; mode_r <= 1'b0;
      res_q <= '0; res_done <= 1'b0;
    end else begin
      res_done <= 1'b0;
      case (state)
        ST_LOAD: if (beat_w) begin
          idx <= idx + 1'b1;
          if (first_w) begin
            mode_r <= mode_static;
            ma_r   <= mag_in_a_w;
            mb_r   <= mag_in_b_w;
            if (mode_static) begin                               // R5
              sa_r <= scale_a;
              sb_r <= scale_b;
            end
          end else begin
            if (mag_in_a_w > ma_r) ma_r <= mag_in_a_w;
            if (mag_in_b_w > mb_r) mb_r <= mag_in_b_w;
          end
          if (last_beat_w) begin
            len_r <= LEN_W'(idx) + LEN_W'(1);
            idx   <= '0;
            k     <= '0;
            state <= mode_eff_w ? ST_MAC : ST_KSA;
          end
        end
        ST_KSA:  state <= ST_WSA;
        ST_WSA:  if (div_done_w) begin sa_r <= div_quo[SC_W-1:0]; state <= ST_KSB; end
        ST_KSB:  state <= ST_WSB;
        ST_WSB:  if (div_done_w) begin sb_r <= div_quo[SC_W-1:0]; state <= ST_MAC; end
        ST_MAC: begin
          k <= k + 1'b1;
          if (last_k_w) state <= ST_KDQ;
        end
        ST_KDQ:  state <= ST_WDQ;
        ST_WDQ:  if (div_done_w) begin
          res_q    <= dq_finish(div_quo, acc_w[ACC_W-1]);
          res_done <= 1'b1;                                      // R9
          state    <= ST_HOLD;
        end
        ST_HOLD: if (res_ack) state <= ST_LOAD;
        default: state <= ST_LOAD;
      endcase
    end
  end

  qdot_mac #(.ACC_W(ACC_W)) mac_i (
    .clk(clk), .rst_n(rst_n), .clr(beat_w && first_w), .en(mac_en_w),
    .a(cur_a_w), .b(cur_b_w), .sa(sa_r), .sb(sb_r),
    .qa(qa_w), .qb(qb_w), .acc(acc_w)
  );

  qdot_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) div_i (
    .clk(clk), .rst_n(rst_n), .start(div_start_w), .num(div_num), .den(div_den),
    .done(div_done_w), .quo(div_quo)
  );
endmodule

// File: rtl/qdot_engine_chk.sv
module qdot_engine_chk import qdot_pkg::*; (
  input logic                    clk,
  input logic                    rst_n,
  input qdot_state_t             state,
  input logic                    in_ready,
  input logic                    res_done,
  input logic                    res_ack,
  input logic signed [OUT_W-1:0] res_q,
  input logic                    mac_en,
  input logic                    mode_r,
  input logic signed [IN_W-1:0]  cur_a,
  input logic signed [IN_W-1:0]  cur_b,
  input logic [IN_W:0]           ma,
  input logic [IN_W:0]           mb,
  input logic signed [Q_W-1:0]   qa,
  input logic signed [Q_W-1:0]   qb
);
  p_no_minus128_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mac_en |-> (qa != -8'sd128) && (qb != -8'sd128));

  p_peak_full_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !mode_r && ma != '0 && mag_of(cur_a) == ma) |-> (qa == 8'sd127 || qa == -8'sd127));

  p_peak_full_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !mode_r && mb != '0 && mag_of(cur_b) == mb) |-> (qb == 8'sd127 || qb == -8'sd127));

  p_zero_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_en && !mode_r && ma == '0) |-> (qa == 8'sd0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !in_ready);

  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && !res_ack) |=> $stable(res_q));

  p_ready_in_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (state == ST_LOAD));
endmodule

bind qdot_engine qdot_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .state(state), .in_ready(in_ready), .res_done(res_done),
  .res_ack(res_ack), .res_q(res_q), .mac_en(mac_en_w), .mode_r(mode_r),
  .cur_a(cur_a_w), .cur_b(cur_b_w), .ma(ma_r), .mb(mb_r), .qa(qa_w), .qb(qb_w)
);

// File: tb/qdot_engine_tb_top.sv
module qdot_engine_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic rst_n, in_valid, in_ready, in_last, mode_static, res_done, res_ack;
  logic signed [15:0] in_a, in_b;
  logic [31:0] scale_a, scale_b;
  logic signed [31:0] res_q;

  qdot_engine dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_last(in_last), .mode_static(mode_static),
    .scale_a(scale_a), .scale_b(scale_b), .res_q(res_q), .res_done(res_done),
    .res_ack(res_ack)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int va [64];
  int vb [64];

  task automatic check(string req, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint q_ref(longint x, longint s);
    longint m = (x < 0) ? -x : x;
    longint r = (2 * m * s + 64'd16777216) / 64'd33554432;
    if (r > 127) r = 127;
    return (x < 0) ? -r : r;
  endfunction

  function automatic longint dyn_scale(longint m);
    return (m == 0) ? 0 : (longint'(127) * 64'd16777216) / m;
  endfunction

  function automatic longint deq_ref(longint acc, longint sa, longint sb);
    logic [127:0] den, num, r;
    den = 128'(sa) * 128'(sb);
    if (den == 0) return 0;
    num = 128'((acc < 0) ? -acc : acc) * (128'(1) << 49) + den;
    r = num / (2 * den);
    if (r > 128'd2147483647) r = 128'd2147483647;
    return (acc < 0) ? -longint'(r) : longint'(r);
  endfunction

  task automatic run_vec(int len, bit mode, longint sa, longint sb, bit use_last,
                         bit flip, string req);
    longint ma = 0, mb = 0, ea, eb, acc = 0, exp_q, held;
    int w = 0;
    for (int i = 0; i < len; i++) begin
      if ((va[i] < 0 ? -va[i] : va[i]) > ma) ma = (va[i] < 0 ? -va[i] : va[i]);
      if ((vb[i] < 0 ? -vb[i] : vb[i]) > mb) mb = (vb[i] < 0 ? -vb[i] : vb[i]);
    end
    ea = mode ? sa : dyn_scale(ma);
    eb = mode ? sb : dyn_scale(mb);
    for (int i = 0; i < len; i++) acc += q_ref(va[i], ea) * q_ref(vb[i], eb);
    exp_q = deq_ref(acc, ea, eb);

    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        mode_static = mode; scale_a = 32'(sa); scale_b = 32'(sb);
        check("R1 ready before first pair", in_ready, 1);
      end else if (flip) begin
        mode_static = ~mode; scale_a = 32'(sa + 77777); scale_b = 32'(sb + 3);
      end
      in_valid = 1; in_a = 16'(va[i]); in_b = 16'(vb[i]);
      in_last = use_last && (i == len - 1);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_last = 0;
    check("R1 vector closed", in_ready, 0);
    while (!res_done && w < 3000) begin @(negedge clk); w++; end
    check("R9 done seen", res_done, 1);
    check(req, res_q, exp_q);
    held = res_q;
    @(negedge clk);
    check("R9 done one cycle", res_done, 0);
    in_valid = 1; in_a = 16'sd1000; in_b = 16'sd1000; in_last = 1;
    @(negedge clk);
    in_valid = 0; in_last = 0;
    check("R9 result held", res_q, held);
    check("R9 stalled while held", in_ready, 0);
    res_ack = 1;
    @(negedge clk);
    res_ack = 0;
    check("R1 ready after ack", in_ready, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; in_valid = 0; in_last = 0; mode_static = 0; res_ack = 0;
    in_a = 0; in_b = 0; scale_a = 0; scale_b = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset ready", in_ready, 1);
    check("R9 reset done", res_done, 0);
    check("R7 reset result", res_q, 0);
    rst_n = 1;

    // R4 dynamic, peaks of both signs
    va[0:3] = '{-1200, 300, 77, 1200}; vb[0:3] = '{500, -2000, 13, 9};
    run_vec(4, 0, 0, 0, 1, 0, "R4 dynamic mixed");
    // R3 rounding and R2/R5 clamp with unit scale: codes 1,-1,127,-127
    va[0:3] = '{128, -128, 32640, -32768}; vb[0:3] = '{256, 512, 256, 512};
    run_vec(4, 1, 65536, 65536, 1, 0, "R3 R2 R5 round and clamp");
    // R8 all-zero dynamic vector
    va[0:2] = '{0, 0, 0}; vb[0:2] = '{700, -20, 5};
    run_vec(3, 0, 0, 0, 1, 0, "R8 zero vector");
    // R8 zero static scale
    va[0:2] = '{900, -20, 5}; vb[0:2] = '{700, -20, 5};
    run_vec(3, 1, 0, 65536, 1, 0, "R8 zero scale");
    // R7 saturation, both signs
    for (int i = 0; i < 8; i++) begin va[i] = 25600; vb[i] = 25600; end
    run_vec(8, 0, 0, 0, 1, 0, "R7 positive saturation");
    for (int i = 0; i < 8; i++) vb[i] = -25600;
    run_vec(8, 0, 0, 0, 1, 0, "R7 negative saturation");
    // single pair vectors
    va[0] = -333; vb[0] = 444;
    run_vec(1, 0, 0, 0, 1, 0, "R1 R4 single pair dynamic");
    run_vec(1, 1, 70000, 40000, 1, 0, "R1 R5 single pair static");
    // R1 length limit without last flag, then a normal vector
    for (int i = 0; i < 64; i++) begin va[i] = i * 37 - 1000; vb[i] = 500 - i * 11; end
    run_vec(64, 0, 0, 0, 0, 0, "R1 R6 length limit");
    va[0:1] = '{100, 200}; vb[0:1] = '{300, 400};
    run_vec(2, 1, 90000, 90000, 1, 0, "R1 vector after limit");
    // R10 mode and scale changes after the first pair
    for (int i = 0; i < 10; i++) begin va[i] = i * 150 - 700; vb[i] = 900 - i * 90; end
    run_vec(10, 0, 50000, 60000, 1, 1, "R10 dynamic latched");
    run_vec(10, 1, 50000, 60000, 1, 1, "R10 static latched");

    // random vectors
    for (int t = 0; t < 40; t++) begin
      int len = 1 + int'($urandom % 64);
      bit mode = 1'($urandom % 2);
      bit big = 1'($urandom % 2);
      longint sa = 4096 + longint'($urandom % 200000);
      longint sb = 4096 + longint'($urandom % 200000);
      for (int i = 0; i < len; i++) begin
        va[i] = big ? int'($urandom % 65536) - 32768 : int'($urandom % 2049) - 1024;
        vb[i] = big ? int'($urandom % 65536) - 32768 : int'($urandom % 2049) - 1024;
      end
      run_vec(len, mode, sa, sb, 1, 0, mode ? "R6 R5 random static" : "R6 R4 random dynamic");
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule